// File: doc/BRIEF.md
# SPI Command-Protocol Slave

This block is an SPI slave that reads a one-byte command at the start of every exchange framed by an active-low chip select. The command sets both the direction and the length of the transfer that follows. Commands 0 to 2 stream a fixed response out on MISO. Commands 3 to 5 take a fixed-length payload from MOSI and keep it in one of three storage buffers. When the last byte of a command has been transferred, the engine waits for a new command. Chip select does not have to toggle between commands.

SCLK, MOSI and chip select enter the system clock domain through two-flop synchronizers. Clock edges are found by comparing the synchronized level with its previous value. The system clock must therefore run at least four times faster than SCLK.

A received payload only becomes visible when its last byte arrives. Until then the bytes land in a shadow copy of the buffer. A registered read port lets the surrounding logic, or a testbench, read the three payload buffers.

Top module: `spi_cmd_slave`

## Requirements
- R1: SPI words are 8 bits, most significant bit first. SCLK idles high, MOSI is sampled on the rising SCLK edge and MISO changes on the falling SCLK edge.
- R2: Commands 0, 1 and 2 return their stored response, starting in the byte slot right after the command:
  - command 0 returns 0x0C;
  - command 1 returns 0x15, 0x16;
  - command 2 returns 0x41, 0x42, 0x43, 0x44, 0x31, 0x32.
- R3: Commands 3, 4 and 5 store a payload of 1, 2 and 6 bytes into buffers 0, 1 and 2. Setting `rd_buf`/`rd_idx` returns the byte in `rd_data` one clock later, with index 0 being the first payload byte. A later payload to the same buffer replaces its contents.
- R4: Once the length of a command is used up, the next byte is decoded as a command while chip select stays low.
- R5: A command byte above 5 is ignored. The slave sends 0xFF during the slot that follows it and decodes the byte after it as a command.
- R6: Bytes clocked while chip select is high have no effect: they change neither the command state nor any buffer.
- R7: Raising chip select in the middle of a command returns the engine to command-wait. A payload cut short this way leaves its buffer unchanged.
- R8: While no response byte is pending (command slots, payload slots, after a response) MISO sends 0xFF. With chip select high, MISO is held high.
- R9: After reset the engine waits for a command and MISO is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, idle high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| rd_buf | input | 2 | Payload buffer to read (0 to 2) |
| rd_idx | input | 3 | Byte index within the buffer |
| rd_data | output | 8 | Byte read, valid one clock after the address |

## Verification
The hardest case to reach is a payload cut short. The master has to raise chip select after some, but not all, bytes of a write command, and only then can the bench show that the shadow bytes never reached the visible buffer. The bench reaches it by overwriting a buffer that already holds known data with a three-byte slice of a six-byte command and then reading all six bytes back. In a second pass it clocks a full write command with chip select high and shows that neither the target buffer nor the command state moved.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 3;
  localparam int BUF_W   = 2;
  localparam int NUM_BUF = 3;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } eng_state_t;

  // byte count for each of the three command slots
  function automatic logic [IDX_W-1:0] cmd_len(input logic [1:0] slot);
    case (slot)
      2'd0:    cmd_len = IDX_W'(1);
      2'd1:    cmd_len = IDX_W'(2);
      default: cmd_len = IDX_W'(6);
    endcase
  endfunction

  // fixed response contents
  function automatic logic [BYTE_W-1:0] resp_byte(input logic [1:0] slot,
                                                  input logic [IDX_W-1:0] idx);
    logic [BYTE_W-1:0] v;
    v = 8'hFF;
    case (slot)
      2'd0: v = 8'd12;
      2'd1: v = (idx == 3'd0) ? 8'h15 : 8'h16;
      2'd2: begin
        case (idx)
          3'd0:    v = 8'h41;
          3'd1:    v = 8'h42;
          3'd2:    v = 8'h43;
          3'd3:    v = 8'h44;
          3'd4:    v = 8'h31;
          default: v = 8'h32;
        endcase
      end
      default: v = 8'hFF;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_cmd_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_act,
  input  logic         sclk_s,
  input  logic         mosi_s,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         miso
);

  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     rx_sh;
  logic [W-1:0]     tx_sh;
  logic [CNT_W-1:0] bit_cnt;
  logic             sclk_q;
  logic             sclk_rise;
  logic             sclk_fall;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b1;
      rx_sh     <= '0;
      tx_sh     <= '1;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
      miso      <= 1'b1;
    end else begin
      sclk_q    <= sclk_s;
      byte_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        tx_sh   <= '1;
        miso    <= 1'b1;
      end else begin
        if (sclk_fall) begin
          miso  <= tx_sh[W-1];
          tx_sh <= {tx_sh[W-2:0], 1'b1};
        end
        if (sclk_rise) begin
          rx_sh <= {rx_sh[W-2:0], mosi_s};
          if (bit_cnt == CNT_W'(W-1)) begin
            bit_cnt   <= '0;
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh[W-2:0], mosi_s};
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
        if (load_en) tx_sh <= load_data;
      end
    end
  end

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst) !cs_act |=> miso); // R8
  AST_DONE_SPACED: assert property (@(posedge clk) disable iff (rst) byte_done |=> !byte_done); // R1
  AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (rst) byte_done |-> $past(sclk_rise && cs_act)); // R1

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_data,
  output logic              wr_en,
  output logic [BUF_W-1:0]  wr_buf,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit,
  output logic [BUF_W-1:0]  commit_buf
);

  eng_state_t       state;
  logic [1:0]       slot;
  logic [IDX_W-1:0] remain;
  logic [IDX_W-1:0] idx;
  logic             cs_q;
  logic             cs_drop;
  logic [1:0]       rx_slot;

  assign cs_drop = cs_q & ~cs_act;
  assign rx_slot = 2'(rx_byte - 8'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_WAIT;
      slot       <= '0;
      remain     <= '0;
      idx        <= '0;
      cs_q       <= 1'b0;
      tx_load    <= 1'b0;
      tx_data    <= '1;
      wr_en      <= 1'b0;
      wr_buf     <= '0;
      wr_idx     <= '0;
      wr_data    <= '0;
      commit     <= 1'b0;
      commit_buf <= '0;
    end else begin
      cs_q    <= cs_act;
      tx_load <= 1'b0;
      wr_en   <= 1'b0;
      commit  <= 1'b0;
      if (cs_drop) begin
        state <= ST_WAIT;
      end else if (byte_done) begin
        case (state)
          ST_WAIT: begin
            if (rx_byte < 8'd3) begin
              state   <= ST_SEND;
              slot    <= rx_byte[1:0];
              remain  <= cmd_len(rx_byte[1:0]);
              idx     <= IDX_W'(1);
              tx_load <= 1'b1;
              tx_data <= resp_byte(rx_byte[1:0], '0);
            end else if (rx_byte < 8'd6) begin
              state  <= ST_RECV;
              slot   <= rx_slot;
              remain <= cmd_len(rx_slot);
              idx    <= '0;
            end
          end
          ST_SEND: begin
            remain <= remain - IDX_W'(1);
            if (remain == IDX_W'(1)) begin
              state <= ST_WAIT;
            end else begin
              tx_load <= 1'b1;
              tx_data <= resp_byte(slot, idx);
              idx     <= idx + IDX_W'(1);
            end
          end
          ST_RECV: begin
            wr_en   <= 1'b1;
            wr_buf  <= BUF_W'(slot);
            wr_idx  <= idx;
            wr_data <= rx_byte;
            idx     <= idx + IDX_W'(1);
            remain  <= remain - IDX_W'(1);
            if (remain == IDX_W'(1)) begin
              commit     <= 1'b1;
              commit_buf <= BUF_W'(slot);
              state      <= ST_WAIT;
            end
          end
          default: state <= ST_WAIT;
        endcase
      end
    end
  end

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (rst) cs_drop |=> state == ST_WAIT); // R7
  AST_BAD_CMD: assert property (@(posedge clk) disable iff (rst) (state == ST_WAIT && byte_done && !cs_drop && rx_byte > 8'd5) |=> (state == ST_WAIT && !tx_load && !wr_en)); // R5
  AST_SEND_EXIT: assert property (@(posedge clk) disable iff (rst) (state == ST_SEND && byte_done && !cs_drop && remain == IDX_W'(1)) |=> state == ST_WAIT); // R4

endmodule

// File: rtl/spi_rx_store.sv
module spi_rx_store
  import spi_cmd_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int NBUF = NUM_BUF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BUF_W-1:0] wr_buf,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             commit,
  input  logic [BUF_W-1:0] commit_buf,
  input  logic [BUF_W-1:0] rd_buf,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);

  localparam int ADDR_W = BUF_W + 1 + IDX_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NSEL   = 1 << BUF_W;

  logic [W-1:0]      mem [DEPTH];
  logic [NSEL-1:0]   act;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;

  // payload bytes land in the bank that is not visible
  assign wr_addr = {wr_buf, ~act[wr_buf], wr_idx};
  assign rd_addr = {rd_buf, act[rd_buf], rd_idx};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) act <= '0;
    else if (commit) act[commit_buf] <= ~act[commit_buf];
  end

  AST_WR_TARGET: assert property (@(posedge clk) disable iff (rst) wr_en |-> (32'(wr_buf) < NBUF)); // R3

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [BUF_W-1:0]  rd_buf,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data
);

  logic [2:0]        pins_s;
  logic              sclk_s;
  logic              cs_act;
  logic              mosi_s;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_data;
  logic              wr_en;
  logic [BUF_W-1:0]  wr_buf;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic              commit;
  logic [BUF_W-1:0]  commit_buf;

  spi_in_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_sclk, spi_cs_n, spi_mosi}),
    .dout (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign cs_act = ~pins_s[1];
  assign mosi_s = pins_s[0];

  spi_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sclk_s    (sclk_s),
    .mosi_s    (mosi_s),
    .load_en   (tx_load),
    .load_data (tx_data),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_cmd_engine u_eng (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .tx_load    (tx_load),
    .tx_data    (tx_data),
    .wr_en      (wr_en),
    .wr_buf     (wr_buf),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .commit     (commit),
    .commit_buf (commit_buf)
  );

  spi_rx_store #(.W(BYTE_W), .NBUF(NUM_BUF)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_buf     (wr_buf),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .commit     (commit),
    .commit_buf (commit_buf),
    .rd_buf     (rd_buf),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data)
  );

endmodule

// File: tb/spi_cmd_slave_tb_top.sv
module spi_cmd_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b1;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic [1:0] rd_buf = '0;
  logic [2:0] rd_idx = '0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  exp_t       exp_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_slave dut_i (
    .clk      (clk),
    .rst      (rst),
    .spi_sclk (sclk),
    .spi_cs_n (cs_n),
    .spi_mosi (mosi),
    .spi_miso (miso),
    .rd_buf   (rd_buf),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // one SPI byte, idle-high clock, master samples MISO just before the rising edge
  task automatic shift_byte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sclk = 1'b0;
      mosi = mo[i];
      repeat (HALF) @(posedge clk);
      @(negedge clk);
      mi[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  // driver: pushes the expected MISO byte, then transfers
  task automatic send(input logic [7:0] mo, input logic [7:0] exp_mi, input string tag);
    exp_t e;
    logic [7:0] mi;
    e.val = exp_mi;
    e.tag = tag;
    exp_q.push_back(e);
    shift_byte(mo, mi);
    got_q.push_back(mi);
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic cs_high();
    repeat (6) @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  task automatic read_buf(input logic [1:0] b, input logic [2:0] i, input logic [7:0] exp,
                          input string tag);
    @(negedge clk);
    rd_buf = b;
    rd_idx = i;
    @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  // monitor: compares captured MISO bytes against the queue
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0 && got_q.size() > 0) begin
        exp_t e;
        logic [7:0] g;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        check(e.tag, g, e.val);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  logic [7:0] dummy;
  logic [7:0] resp2 [6];
  logic [7:0] pay5 [6];

  initial begin
    resp2 = '{8'h41, 8'h42, 8'h43, 8'h44, 8'h31, 8'h32};
    pay5  = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5};
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 miso high after reset", {7'd0, miso}, 8'd1);

    // R2 / R4: several reads in one frame
    cs_low();
    send(8'h02, 8'hFF, "R8 idle during command");
    for (int i = 0; i < 6; i++) send(8'hFF, resp2[i], "R2 cmd2 response");
    send(8'h01, 8'hFF, "R4 next command in same frame");
    send(8'hFF, 8'h15, "R2 cmd1 byte0");
    send(8'hFF, 8'h16, "R2 cmd1 byte1");
    send(8'h00, 8'hFF, "R4 cmd0 decoded");
    send(8'hFF, 8'h0C, "R2 cmd0 response");
    cs_high();
    @(negedge clk);
    check("R8 miso high with cs high", {7'd0, miso}, 8'd1);

    // R3 writes
    cs_low();
    send(8'h03, 8'hFF, "R8 command slot");
    send(8'hA5, 8'hFF, "R8 payload slot");
    send(8'h04, 8'hFF, "R4 command after payload");
    send(8'h11, 8'hFF, "R8 payload slot");
    send(8'h22, 8'hFF, "R8 payload slot");
    send(8'h05, 8'hFF, "R4 command after payload");
    for (int i = 0; i < 6; i++) send(pay5[i], 8'hFF, "R8 payload slot");
    cs_high();
    read_buf(2'd0, 3'd0, 8'hA5, "R3 buffer0");
    read_buf(2'd1, 3'd0, 8'h11, "R3 buffer1 idx0");
    read_buf(2'd1, 3'd1, 8'h22, "R3 buffer1 idx1");
    for (int i = 0; i < 6; i++) read_buf(2'd2, 3'(i), pay5[i], "R3 buffer2");

    // R5 invalid commands
    cs_low();
    send(8'h07, 8'hFF, "R5 invalid command slot");
    send(8'h00, 8'hFF, "R5 after invalid");
    send(8'hFF, 8'h0C, "R5 command after invalid decoded");
    send(8'hFF, 8'hFF, "R5 0xFF ignored");
    send(8'h01, 8'hFF, "R5 command slot");
    send(8'hFF, 8'h15, "R5 decode after 0xFF");
    send(8'hFF, 8'h16, "R2 cmd1 byte1");
    cs_high();

    // R6 bytes with chip select high are discarded
    shift_byte(8'h04, dummy);
    shift_byte(8'h55, dummy);
    shift_byte(8'h66, dummy);
    shift_byte(8'h01, dummy);
    read_buf(2'd1, 3'd0, 8'h11, "R6 buffer1 idx0 unchanged");
    read_buf(2'd1, 3'd1, 8'h22, "R6 buffer1 idx1 unchanged");
    cs_low();
    send(8'h00, 8'hFF, "R6 state unchanged");
    send(8'hFF, 8'h0C, "R6 command decoded");
    cs_high();

    // R7 partial payload and aborted response
    cs_low();
    send(8'h05, 8'hFF, "R7 command slot");
    send(8'h90, 8'hFF, "R7 partial");
    send(8'h91, 8'hFF, "R7 partial");
    send(8'h92, 8'hFF, "R7 partial");
    cs_high();
    for (int i = 0; i < 6; i++) read_buf(2'd2, 3'(i), pay5[i], "R7 buffer2 unchanged");
    cs_low();
    send(8'h02, 8'hFF, "R7 command slot");
    send(8'hFF, 8'h41, "R2 cmd2 byte0");
    send(8'hFF, 8'h42, "R2 cmd2 byte1");
    cs_high();
    cs_low();
    send(8'h01, 8'hFF, "R7 wait after abort");
    send(8'hFF, 8'h15, "R7 new command after abort");
    send(8'hFF, 8'h16, "R2 cmd1 byte1");
    cs_high();

    // R3 overwrite buffer 0, with R1 bit ordering pattern
    cs_low();
    send(8'h03, 8'hFF, "R3 command slot");
    send(8'h3C, 8'hFF, "R3 payload slot");
    cs_high();
    read_buf(2'd0, 3'd0, 8'h3C, "R1 R3 buffer0 overwrite");
    read_buf(2'd1, 3'd1, 8'h22, "R3 buffer1 untouched");

    repeat (20) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule